// File: doc/BRIEF.md
# Multi-channel gamma lookup memory

This block keeps a set of 8-bit gamma tables for three display channels and uses them to correct 24-bit RGB pixels. Each channel owns three 256-entry tables, one for each colour. All nine tables sit in one flat address space of 2304 entries. A host fills the tables through two strobed registers. An address register holds the current entry address and a flag that says whether the address steps forward by one after every data write. A data register writes one 8-bit entry at the current address. With the flag set, a whole channel is loaded as one stream: 256 red entries, then 256 green, then 256 blue.

On the pixel side, a channel number and a pixel arrive with a valid strobe. Each colour component indexes that channel's table for the same colour. The corrected pixel and a matching valid come out one clock later. A per-channel enable input turns correction off, and the pixel then passes through unchanged. After reset every table holds an identity ramp, so an enabled channel passes pixels through unchanged until the host loads new values.

Top module: `gamma_lut_mem`

## Requirements
- R1: After reset, out_valid and out_rgb are 0. Every table entry i holds the value i, so an enabled channel returns its input pixel unchanged until the host writes to it.
- R2: A pulse on addr_wr loads addr_wdata into the current address and addr_autoinc into the step flag. A pulse on data_wr writes data_wdata into the entry at the current address.
- R3: When the step flag is 1, each data_wr advances the current address by one. When it is 0, the address holds, so repeated writes land in the same entry and the next entry is left unchanged.
- R4: The entry for channel c, colour k and index i sits at address c*768 + k*256 + i, where k is 0 for red, 1 for green and 2 for blue. A write to one channel's tables leaves the other channels' lookups unchanged.
- R5: Pixels are coded red in pix_rgb[23:16], green in [15:8] and blue in [7:0]. For an enabled channel, each output component is the entry of that channel's table for the same colour, indexed by the input component. out_rgb and out_valid appear on the clock after pix_valid, including for back-to-back pixels.
- R6: Correction is applied only while gamma_en bit c is 1 for channel c. When that bit is 0, or when pix_ch is 3, out_rgb equals the input pixel.
- R7: A step from address 2303 wraps to 0. So does a step from any address above 2303.
- R8: If a data write and a lookup hit the same entry in the same cycle, the lookup returns the value the entry held before the write.
- R9: A data write at an address above 2303 changes no table entry.
- R10: When addr_wr and data_wr pulse in the same cycle, the data goes to the old address and the address then takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Strobe that loads the address register |
| addr_wdata | input | 12 | New entry address |
| addr_autoinc | input | 1 | Step flag loaded together with the address |
| data_wr | input | 1 | Strobe that writes one table entry |
| data_wdata | input | 8 | Entry value, the upper byte of a 16-bit gamma value |
| gamma_en | input | 3 | Correction enable, bit c for channel c |
| pix_valid | input | 1 | Input pixel strobe |
| pix_ch | input | 2 | Channel of the input pixel |
| pix_rgb | input | 24 | Input pixel, red in the upper byte |
| out_valid | output | 1 | Output pixel strobe, one clock after pix_valid |
| out_rgb | output | 24 | Corrected or passed-through pixel |

## Verification
The tests first run pixels through identity tables on all three channels. Then channel 1 gets a distinct function for each colour, such as inversion, XOR or offset, and lookups on channels 1 and 0 show that the colours stay in their own lanes and that the channels do not share tables. Writes with the step flag clear, writes across the last address, writes above the last address, and a combined address-and-data pulse each show a different address-sequencing fault. A write and a lookup that hit the same entry in one cycle show whether the read returns the old value or the new one. Disabled channels and channel 3 show the bypass path.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  typedef enum int {COL_RED = 0, COL_GREEN = 1, COL_BLUE = 2} colour_e;
  localparam int COLOURS = 3;

  // Bit position of a colour component inside a packed pixel (red on top)
  function automatic int comp_lsb(int col, int w);
    return (COLOURS - 1 - col) * w;
  endfunction
endpackage

// File: rtl/gamma_bank.sv
module gamma_bank #(
  parameter int IDX_W = 8,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] rd_data
);
  logic [IDX_W-1:0] tbl [ENTRIES];

  // Identity ramp on reset; single write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= IDX_W'(i);
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_data;
    end
  end

  // Combinational read: sampled downstream at the same edge as a write,
  // so a colliding lookup sees the pre-write value
  assign rd_data = tbl[rd_idx];
endmodule

// File: rtl/gamma_host_port.sv
module gamma_host_port #(
  parameter int IDX_W  = 8,
  parameter int BANKS  = 9,
  parameter int ADDR_W = 12,
  localparam int DEPTH  = BANKS * (1 << IDX_W),
  localparam int BSEL_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              inc_in,
  input  logic              data_wr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_inc,
  output logic [BANKS-1:0]  bank_we,
  output logic [IDX_W-1:0]  wr_idx
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              inc_q, inc_d;
  logic [BSEL_W-1:0] bank_sel;

  assign bank_sel = addr_q[ADDR_W-1:IDX_W];
  assign wr_idx   = addr_q[IDX_W-1:0];

  // Decode the bank: addresses above the last bank select nothing
  generate
    for (genvar k = 0; k < BANKS; k++) begin : g_we
      assign bank_we[k] = data_wr && (bank_sel == BSEL_W'(k));
    end
  endgenerate

  always_comb begin
    addr_d = addr_q;
    inc_d  = inc_q;
    if (addr_wr) begin
      addr_d = addr_in;
      inc_d  = inc_in;
    end else if (data_wr && inc_q) begin
      if (addr_q >= ADDR_W'(DEPTH - 1)) addr_d = '0;
      else                               addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inc_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      inc_q  <= inc_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_inc  = inc_q;
endmodule

// File: rtl/gamma_lookup.sv
module gamma_lookup
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int IDX_W  = 8,
  parameter int CH_W   = 2,
  localparam int BANKS = NUM_CH * COLOURS,
  localparam int PIX_W = COLOURS * IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pix_valid,
  input  logic [CH_W-1:0]             pix_ch,
  input  logic [PIX_W-1:0]            pix_rgb,
  input  logic [NUM_CH-1:0]           gamma_en,
  input  logic [BANKS-1:0][IDX_W-1:0] bank_rd,
  output logic [BANKS-1:0][IDX_W-1:0] rd_idx,
  output logic                        out_valid,
  output logic [PIX_W-1:0]            out_rgb
);
  logic [PIX_W-1:0] corr, rgb_d, rgb_q;
  logic             valid_q;

  // Every bank is addressed by the component of its own colour
  generate
    for (genvar k = 0; k < BANKS; k++) begin : g_idx
      assign rd_idx[k] = pix_rgb[comp_lsb(k % COLOURS, IDX_W) +: IDX_W];
    end
  endgenerate

  always_comb begin
    corr = pix_rgb;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (pix_ch == CH_W'(ch) && gamma_en[ch]) begin
        for (int c = 0; c < COLOURS; c++)
          corr[comp_lsb(c, IDX_W) +: IDX_W] = bank_rd[ch*COLOURS + c];
      end
    end
  end

  assign rgb_d = pix_valid ? corr : rgb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rgb_q   <= '0;
    end else begin
      valid_q <= pix_valid;
      rgb_q   <= rgb_d;
    end
  end

  assign out_valid = valid_q;
  assign out_rgb   = rgb_q;
endmodule

// File: rtl/gamma_lut_mem.sv
module gamma_lut_mem
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int IDX_W  = 8,
  parameter int CH_W   = 2,
  localparam int BANKS  = NUM_CH * COLOURS,
  localparam int DEPTH  = BANKS * (1 << IDX_W),
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PIX_W  = COLOURS * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              addr_autoinc,
  input  logic              data_wr,
  input  logic [IDX_W-1:0]  data_wdata,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              pix_valid,
  input  logic [CH_W-1:0]   pix_ch,
  input  logic [PIX_W-1:0]  pix_rgb,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_rgb
);
  logic [ADDR_W-1:0]           host_addr;
  logic                        host_inc;
  logic [BANKS-1:0]            bank_we;
  logic [IDX_W-1:0]            wr_idx;
  logic [BANKS-1:0][IDX_W-1:0] rd_idx;
  logic [BANKS-1:0][IDX_W-1:0] bank_rd;

  gamma_host_port #(.IDX_W(IDX_W), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_wdata),
    .inc_in(addr_autoinc), .data_wr(data_wr), .cur_addr(host_addr),
    .cur_inc(host_inc), .bank_we(bank_we), .wr_idx(wr_idx)
  );

  generate
    for (genvar k = 0; k < BANKS; k++) begin : g_bank
      gamma_bank #(.IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bank_we[k]), .wr_idx(wr_idx),
        .wr_data(data_wdata), .rd_idx(rd_idx[k]), .rd_data(bank_rd[k])
      );
    end
  endgenerate

  gamma_lookup #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .CH_W(CH_W)) u_look (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ch(pix_ch),
    .pix_rgb(pix_rgb), .gamma_en(gamma_en), .bank_rd(bank_rd),
    .rd_idx(rd_idx), .out_valid(out_valid), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/gamma_lut_mem_chk.sv
module gamma_lut_mem_chk #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 2304,
  parameter int PIX_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_wr,
  input logic [ADDR_W-1:0] addr_wdata,
  input logic              data_wr,
  input logic [NUM_CH-1:0] gamma_en,
  input logic              pix_valid,
  input logic [CH_W-1:0]   pix_ch,
  input logic [PIX_W-1:0]  pix_rgb,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_rgb,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_inc
);
  logic [NUM_CH-1:0] ch_mask;
  logic              en_hit;
  assign ch_mask = NUM_CH'(1) << pix_ch;
  assign en_hit  = |(gamma_en & ch_mask);

  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !en_hit) |=> (out_rgb == $past(pix_rgb)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && !host_inc) |=> $stable(host_addr));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && host_inc && host_addr == ADDR_W'(DEPTH - 1))
    |=> (host_addr == '0));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (host_addr == $past(addr_wdata)));
endmodule

bind gamma_lut_mem gamma_lut_mem_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
  .data_wr(data_wr), .gamma_en(gamma_en), .pix_valid(pix_valid),
  .pix_ch(pix_ch), .pix_rgb(pix_rgb), .out_valid(out_valid),
  .out_rgb(out_rgb), .host_addr(host_addr), .host_inc(host_inc)
);

// File: tb/test_gamma_lut_mem.sv
`timescale 1ns/1ps
module test_gamma_lut_mem;
  localparam int DEPTH = 2304;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 1'b0;
  logic [11:0] addr_wdata = '0;
  logic        addr_autoinc = 1'b0;
  logic        data_wr = 1'b0;
  logic [7:0]  data_wdata = '0;
  logic [2:0]  gamma_en = '0;
  logic        pix_valid = 1'b0;
  logic [1:0]  pix_ch = '0;
  logic [23:0] pix_rgb = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int checks = 0;
  int errors = 0;
  int model [DEPTH];
  int bm_addr = 0;
  bit bm_inc = 0;
  logic [23:0] q_exp [$];
  string       q_tag [$];

  gamma_lut_mem i_gamma_lut_mem (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .addr_autoinc(addr_autoinc), .data_wr(data_wr), .data_wdata(data_wdata),
    .gamma_en(gamma_en), .pix_valid(pix_valid), .pix_ch(pix_ch),
    .pix_rgb(pix_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
  );

  always #10 clk = ~clk;

  function automatic logic [23:0] expect_pix(int ch, logic [23:0] rgb);
    logic [23:0] r;
    if (ch > 2 || !gamma_en[ch]) return rgb;
    r[23:16] = 8'(model[ch*768 +       rgb[23:16]]);
    r[15:8]  = 8'(model[ch*768 + 256 + rgb[15:8]]);
    r[7:0]   = 8'(model[ch*768 + 512 + rgb[7:0]]);
    return r;
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %06h expected %06h", tag, act, exp);
    end
  endtask

  // Model of the host write side
  task automatic model_data(int v);
    if (bm_addr < DEPTH) model[bm_addr] = v & 255;
    if (bm_inc) bm_addr = (bm_addr >= DEPTH - 1) ? 0 : bm_addr + 1;
  endtask

  task automatic set_addr(int a, bit inc);
    @(negedge clk);
    pix_valid = 1'b0;
    addr_wr = 1'b1; addr_wdata = 12'(a); addr_autoinc = inc;
    bm_addr = a; bm_inc = inc;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic write_data(int v);
    @(negedge clk);
    pix_valid = 1'b0;
    data_wr = 1'b1; data_wdata = 8'(v);
    model_data(v);
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  // Driver: one lookup per call, back to back until idle()
  task automatic lookup(int ch, logic [23:0] rgb, string tag);
    @(negedge clk);
    pix_valid = 1'b1; pix_ch = 2'(ch); pix_rgb = rgb;
    q_exp.push_back(expect_pix(ch, rgb));
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // Monitor: compares each produced pixel against the queue head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        check("R5 unexpected out_valid", out_rgb, 24'hxxxxxx);
      end else begin
        check(q_tag.pop_front(), out_rgb, q_exp.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = i % 256;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out_valid", {23'd0, out_valid}, 24'd0);
    check("R1 reset out_rgb", out_rgb, 24'd0);
    gamma_en = 3'b111;

    // R1 identity after reset, back-to-back R5
    lookup(0, 24'h123456, "R1 identity ch0");
    lookup(1, 24'hFF0080, "R1 identity ch1");
    lookup(2, 24'h00FFAA, "R1 identity ch2");
    idle();

    // R2/R4: stream all of channel 1 with step flag
    set_addr(768, 1'b1);
    for (int i = 0; i < 256; i++) write_data(255 - i);
    for (int i = 0; i < 256; i++) write_data(i ^ 8'h5A);
    for (int i = 0; i < 256; i++) write_data((i + 37) & 255);
    lookup(1, 24'h000000, "R4 ch1 colour lanes a");
    lookup(1, 24'h10F0C8, "R4 ch1 colour lanes b");
    lookup(1, 24'hFFFFFF, "R5 ch1 top entries");
    lookup(0, 24'h10F0C8, "R4 ch0 untouched");
    lookup(2, 24'h10F0C8, "R4 ch2 untouched");
    idle();
    lookup(1, 24'h7F807E, "R5 ch1 after gap");
    idle();

    // R6 bypass
    gamma_en = 3'b101;
    lookup(1, 24'h10F0C8, "R6 ch1 disabled");
    lookup(3, 24'hABCDEF, "R6 channel 3");
    lookup(0, 24'h0A0B0C, "R6 ch0 still enabled");
    idle();
    gamma_en = 3'b111;

    // R3 no step: two writes to ch2 green 10, entry 11 untouched
    set_addr(2*768 + 256 + 10, 1'b0);
    write_data(8'h11);
    write_data(8'h22);
    lookup(2, 24'h000A00, "R3 held address last write");
    lookup(2, 24'h000B00, "R3 next entry unchanged");
    idle();

    // R7 wrap from the last entry
    set_addr(2302, 1'b1);
    write_data(8'hC1);
    write_data(8'hC2);
    write_data(8'hC3);
    lookup(2, 24'h0000FE, "R7 entry 2302");
    lookup(2, 24'h0000FF, "R7 entry 2303");
    lookup(0, 24'h000000, "R7 wrapped to entry 0");
    idle();

    // R9 writes above the last entry; step from there wraps (R7)
    set_addr(2400, 1'b1);
    write_data(8'hEE);
    write_data(8'h99);
    lookup(0, 24'h606060, "R9 out-of-range write dropped");
    lookup(0, 24'h000000, "R7 wrap from above last entry");
    idle();

    // R8 collision: write ch0 green 50 and look it up in the same cycle
    set_addr(256 + 50, 1'b1);
    @(negedge clk);
    data_wr = 1'b1; data_wdata = 8'hAB;
    pix_valid = 1'b1; pix_ch = 2'd0; pix_rgb = 24'h003200;
    q_exp.push_back(expect_pix(0, 24'h003200));
    q_tag.push_back("R8 collision old value");
    model_data(8'hAB);
    @(negedge clk);
    data_wr = 1'b0; pix_valid = 1'b0;
    lookup(0, 24'h003200, "R8 new value after write");
    idle();

    // R10 address load and data write in the same cycle
    set_addr(512 + 5, 1'b1);
    @(negedge clk);
    addr_wr = 1'b1; addr_wdata = 12'(512 + 9); addr_autoinc = 1'b1;
    data_wr = 1'b1; data_wdata = 8'h3C;
    if (bm_addr < DEPTH) model[bm_addr] = 8'h3C;
    bm_addr = 512 + 9; bm_inc = 1'b1;
    @(negedge clk);
    addr_wr = 1'b0; data_wr = 1'b0;
    write_data(8'hC4);
    lookup(0, 24'h000005, "R10 data to old address");
    lookup(0, 24'h000009, "R10 next data to new address");
    lookup(0, 24'h000006, "R10 no step past old address");
    idle();

    repeat (4) @(negedge clk);
    check("R5 all results produced", 24'(q_exp.size()), 24'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule